// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Generator

This block produces the serial clock and the active-low chip-select for an SPI master, working from the system reference clock. A 32-bit configuration word sets the rate through a 3-bit power-of-two divider field. It also sets clock polarity and phase, master enable, and a manual chip-select mode. From these settings the block drives the `sclk` and `cs_n` pins. It also gives a data shifter one-cycle launch and sample strobes that line up with the clock edges on which data should change and be captured.

When manual mode is off, chip-select follows a request from the shifter. When manual mode is on, chip-select copies a level bit in the configuration word. The serial clock runs only while chip-select is asserted. A new divider setting is loaded into the active divider only while chip-select is deasserted, so a running frame keeps a steady bit period. The block also outputs a loopback-timing word. Bit 5 of that word tells the receive path to sample read data with an internal loopback clock, and the block sets it only at the fastest rate.

Top module: `spi_sck_gen`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, both strobes are 0, `cfg_rdata` is 0x00020000 and `lpbk_cfg` is 0x00000020.
- R2: While `cs_n` is low, `sclk` toggles every 2^x reference cycles, so its period is 2<<x cycles, where x is the active divider. The first toggle comes 2^x cycles after the cycle in which `cs_n` goes low.
- R3: While `cs_n` is high, `sclk` rests at the polarity bit (configuration bit 1) of the configuration word held in the previous cycle.
- R4: The leading edge of a frame's clock moves `sclk` away from its idle level, and the trailing edge moves it back. With phase bit (bit 2) at 0, `sample_stb` pulses with each leading edge and `launch_stb` with each trailing edge. With phase 1 the roles swap. A strobe is high in the same cycle that `sclk` shows the new level, and the two strobes are never high together.
- R5: When the master enable bit (bit 0) is 0, `cs_n` goes high one cycle later and stays high, whatever the request and manual settings are.
- R6: With master enable set and the manual-select bit (bit 14) set, `cs_n` copies configuration bit 10 one cycle later, and the request input is ignored.
- R7: With master enable set and bit 14 clear, `cs_n` is the inverse of `xfer_req`, delayed by one cycle.
- R8: The active divider loads the divider field (bits 5:3) in every cycle in which `cs_n` is high, and holds its value while `cs_n` is low.
- R9: A write with `cfg_we` stores `cfg_wdata`, which shows on `cfg_rdata` in the next cycle. Reserved bit 17 always reads back as 1.
- R10: `lpbk_cfg` is 0x00000020 (loopback sampling, bit 5) when the active divider is 0, and 0 at every other divider value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to store |
| xfer_req | input | 1 | Shifter request for chip-select when manual mode is off |
| cfg_rdata | output | 32 | Stored configuration word, with bit 17 forced to 1 |
| lpbk_cfg | output | 32 | Loopback-timing word; bit 5 selects loopback sampling |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip-select |
| launch_stb | output | 1 | One-cycle pulse on the edge where the shifter drives new data |
| sample_stb | output | 1 | One-cycle pulse on the edge where the shifter captures data |

## Verification
The bench builds the block with its default parameters: a 3-bit divider field, which gives half-periods of 1 to 128 reference cycles, inside a 32-bit configuration word. The bench runs frames at divider values 0, 2, 3 and 7 under every polarity and phase combination, so both the fastest rate (with loopback sampling on) and the slowest rate are exercised. It rewrites the divider in the middle of a frame to show that the running rate holds and that the new rate takes over once chip-select rises. It also covers manual select and master-disable, where the request input must have no effect on chip-select.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

    localparam int CFG_W      = 32;
    localparam int DIV_W      = 3;
    localparam int EN_BIT     = 0;
    localparam int CPOL_BIT   = 1;
    localparam int CPHA_BIT   = 2;
    localparam int DIV_LSB    = 3;
    localparam int CS_LVL_BIT = 10;
    localparam int MANUAL_BIT = 14;
    localparam int RSVD_BIT   = 17;
    localparam int LPBK_BIT   = 5;

    typedef struct packed {
        logic             master_en;
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
        logic             cs_level;
        logic             manual;
    } sck_cfg_t;

endpackage

// File: rtl/spi_sck_cfg.sv
module spi_sck_cfg
    import spi_sck_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output sck_cfg_t     fields
);
    localparam logic [W-1:0] RSVD_MASK = W'(1) << RSVD_BIT;

    typedef struct packed {
        logic [W-1:0] word;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata            = st_q.word | RSVD_MASK;
    assign fields.master_en = st_q.word[EN_BIT];
    assign fields.cpol      = st_q.word[CPOL_BIT];
    assign fields.cpha      = st_q.word[CPHA_BIT];
    assign fields.div       = st_q.word[DIV_LSB +: DIV_W];
    assign fields.cs_level  = st_q.word[CS_LVL_BIT];
    assign fields.manual    = st_q.word[MANUAL_BIT];

endmodule

// File: rtl/spi_sck_csel.sv
module spi_sck_csel
    import spi_sck_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int W  = CFG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_en,
    input  logic          manual,
    input  logic          cs_level,
    input  logic          xfer_req,
    input  logic [DW-1:0] div_cfg,
    output logic          cs_n,
    output logic [DW-1:0] div_act,
    output logic [W-1:0]  lpbk_cfg
);
    localparam logic [W-1:0] LPBK_WORD = W'(1) << LPBK_BIT;

    typedef struct packed {
        logic          cs_n;
        logic [DW-1:0] div;
    } csel_state_t;

    csel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!master_en) begin
            st_d.cs_n = 1'b1;
        end else if (manual) begin
            st_d.cs_n = cs_level;
        end else begin
            st_d.cs_n = ~xfer_req;
        end
        if (st_q.cs_n) begin
            st_d.div = div_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_n <= 1'b1;
            st_q.div  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n     = st_q.cs_n;
    assign div_act  = st_q.div;
    assign lpbk_cfg = (st_q.div == '0) ? LPBK_WORD : '0;

endmodule

// File: rtl/spi_sck_tick.sv
module spi_sck_tick
    import spi_sck_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic [DW-1:0] div_act,
    input  logic          cpol,
    input  logic          cpha,
    output logic          sclk,
    output logic          launch_stb,
    output logic          sample_stb
);
    localparam int CNT_W = (1 << DW) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             sclk;
        logic             launch;
        logic             sample;
    } tick_state_t;

    tick_state_t      st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             edge_hit;
    logic             leading;

    always_comb begin
        limit    = ~({CNT_W{1'b1}} << div_act);
        edge_hit = 1'b0;
        leading  = 1'b0;
        st_d     = st_q;
        if (cs_n) begin
            st_d.cnt    = '0;
            st_d.active = 1'b0;
        end else if (st_q.cnt == limit) begin
            st_d.cnt    = '0;
            st_d.active = ~st_q.active;
            edge_hit    = 1'b1;
            leading     = ~st_q.active;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.launch = edge_hit & (cpha ? leading : ~leading);
        st_d.sample = edge_hit & (cpha ? ~leading : leading);
        st_d.sclk   = cpol ^ st_d.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk       = st_q.sclk;
    assign launch_stb = st_q.launch;
    assign sample_stb = st_q.sample;

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
    import spi_sck_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             xfer_req,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic [CFG_W-1:0] lpbk_cfg,
    output logic             sclk,
    output logic             cs_n,
    output logic             launch_stb,
    output logic             sample_stb
);
    sck_cfg_t         cfg;
    logic [DIV_W-1:0] div_act;

    spi_sck_cfg #(.W(CFG_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .fields (cfg)
    );

    spi_sck_csel #(.DW(DIV_W), .W(CFG_W)) u_csel (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (cfg.master_en),
        .manual    (cfg.manual),
        .cs_level  (cfg.cs_level),
        .xfer_req  (xfer_req),
        .div_cfg   (cfg.div),
        .cs_n      (cs_n),
        .div_act   (div_act),
        .lpbk_cfg  (lpbk_cfg)
    );

    spi_sck_tick #(.DW(DIV_W)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .div_act    (div_act),
        .cpol       (cfg.cpol),
        .cpha       (cfg.cpha),
        .sclk       (sclk),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );

endmodule

// File: rtl/spi_sck_gen_chk.sv
module spi_sck_gen_chk
    import spi_sck_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             sclk,
    input logic             cs_n,
    input logic             launch_stb,
    input logic             sample_stb,
    input logic [DIV_W-1:0] div_act
);
    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> sclk == $past(cfg_rdata[CPOL_BIT]));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch_stb && sample_stb));

    // R4
    strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_stb || sample_stb) |-> !$past(cs_n));

    // R5
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[EN_BIT] |=> cs_n);

    // R6
    manual_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[EN_BIT] && cfg_rdata[MANUAL_BIT]) |=> cs_n == $past(cfg_rdata[CS_LVL_BIT]));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> div_act == $past(div_act));

    // R9
    rsvd_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[RSVD_BIT]);

endmodule

bind spi_sck_gen spi_sck_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb),
    .div_act    (div_act)
);

// File: tb/spi_sck_gen_test.sv
module spi_sck_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        xfer_req = 1'b0;
    logic [31:0] cfg_rdata;
    logic [31:0] lpbk_cfg;
    logic        sclk;
    logic        cs_n;
    logic        launch_stb;
    logic        sample_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    spi_sck_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .xfer_req   (xfer_req),
        .cfg_rdata  (cfg_rdata),
        .lpbk_cfg   (lpbk_cfg),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );

    // Behavioural reference model
    logic [31:0] m_cfg;
    bit          m_csn, m_act, m_sclk, m_launch, m_sample;
    int          m_div, m_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = 0; m_csn = 1; m_act = 0; m_sclk = 0;
            m_launch = 0; m_sample = 0; m_div = 0; m_cnt = 0;
        end else begin
            bit nxt_csn, edge_now, lead;
            int half;
            half     = 1 << m_div;
            edge_now = 0;
            lead     = 0;
            if (!m_cfg[0])      nxt_csn = 1;
            else if (m_cfg[14]) nxt_csn = m_cfg[10];
            else                nxt_csn = !xfer_req;
            if (m_csn) begin
                m_cnt = 0; m_act = 0;
            end else begin
                m_cnt = m_cnt + 1;
                if (m_cnt == half) begin
                    m_cnt = 0; lead = !m_act; m_act = !m_act; edge_now = 1;
                end
            end
            m_launch = edge_now && (m_cfg[2] ? lead : !lead);
            m_sample = edge_now && (m_cfg[2] ? !lead : lead);
            m_sclk   = m_cfg[1] ^ m_act;
            if (m_csn) m_div = int'(m_cfg[5:3]);
            m_csn = nxt_csn;
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7", "cs_n", {31'b0, cs_n}, {31'b0, m_csn});
            chk("R2", "sclk", {31'b0, sclk}, {31'b0, m_sclk});
            chk("R4", "launch", {31'b0, launch_stb}, {31'b0, m_launch});
            chk("R4", "sample", {31'b0, sample_stb}, {31'b0, m_sample});
            chk("R9", "readback", cfg_rdata, m_cfg | 32'h0002_0000);
            chk("R10", "loopback", lpbk_cfg, (m_div == 0) ? 32'h20 : 32'h0);
        end
    end

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        cfg_wdata = w; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] mk(input bit en, input bit pol, input bit pha,
                                       input int dv, input bit man, input bit lvl);
        logic [31:0] w;
        w = '0;
        w[0] = en; w[1] = pol; w[2] = pha; w[5:3] = dv[2:0];
        w[14] = man; w[10] = lvl;
        return w;
    endfunction

    // measure cycles between two successive sclk toggles
    task automatic half_period(output int n);
        logic p;
        @(negedge clk);
        p = sclk;
        while (sclk === p) @(negedge clk);
        p = sclk; n = 0;
        while (sclk === p) begin @(negedge clk); n++; end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        done = 1'b1;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        int h;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n reset", {31'b0, cs_n}, 32'd1);
        chk("R1", "sclk reset", {31'b0, sclk}, 32'd0);
        chk("R1", "strobes reset", {30'b0, launch_stb, sample_stb}, 32'd0);
        chk("R1", "readback reset", cfg_rdata, 32'h0002_0000);
        chk("R1", "loopback reset", lpbk_cfg, 32'h20);
        rst_n = 1'b1;

        // R2/R4/R10 fastest rate, mode 0
        wr(mk(1, 0, 0, 0, 0, 0));
        xfer_req = 1'b1;
        half_period(h);
        chk("R2", "half period div0", h, 1);
        chk("R10", "loopback div0", lpbk_cfg, 32'h20);
        repeat (10) @(negedge clk);
        xfer_req = 1'b0;
        repeat (4) @(negedge clk);

        // R3 polarity 1 idle, R2 div 2, phase 1
        wr(mk(1, 1, 1, 2, 0, 0));
        repeat (3) @(negedge clk);
        chk("R3", "idle high", {31'b0, sclk}, 32'd1);
        chk("R10", "loopback div2", lpbk_cfg, 32'h0);
        xfer_req = 1'b1;
        half_period(h);
        chk("R2", "half period div2", h, 4);

        // R8 change divider mid-frame: rate must hold
        wr(mk(1, 1, 1, 3, 0, 0));
        half_period(h);
        chk("R8", "held rate in frame", h, 4);
        xfer_req = 1'b0;
        repeat (6) @(negedge clk);
        xfer_req = 1'b1;
        half_period(h);
        chk("R8", "new rate next frame", h, 8);
        repeat (20) @(negedge clk);
        xfer_req = 1'b0;
        repeat (4) @(negedge clk);

        // R4 polarity 0 phase 1 and polarity 1 phase 0
        wr(mk(1, 0, 1, 1, 0, 0));
        xfer_req = 1'b1;
        repeat (30) @(negedge clk);
        xfer_req = 1'b0;
        repeat (4) @(negedge clk);
        wr(mk(1, 1, 0, 0, 0, 0));
        xfer_req = 1'b1;
        repeat (20) @(negedge clk);
        xfer_req = 1'b0;
        repeat (4) @(negedge clk);

        // R6 manual select: request ignored
        wr(mk(1, 0, 0, 1, 1, 0));
        repeat (2) @(negedge clk);
        chk("R6", "manual low", {31'b0, cs_n}, 32'd0);
        repeat (20) @(negedge clk);
        wr(mk(1, 0, 0, 1, 1, 1));
        xfer_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", "manual high ignores req", {31'b0, cs_n}, 32'd1);
        chk("R3", "idle low", {31'b0, sclk}, 32'd0);

        // R5 master disabled with request
        wr(mk(0, 0, 0, 0, 1, 0));
        repeat (5) @(negedge clk);
        chk("R5", "disabled cs", {31'b0, cs_n}, 32'd1);
        xfer_req = 1'b0;

        // R2 slowest rate
        wr(mk(1, 0, 0, 7, 0, 0));
        xfer_req = 1'b1;
        half_period(h);
        chk("R2", "half period div7", h, 128);
        xfer_req = 1'b0;
        repeat (6) @(negedge clk);

        // R9 arbitrary readback
        wr(32'hA5A5_0000);
        @(negedge clk);
        chk("R9", "readback pattern", cfg_rdata, 32'hA5A7_0000);
        repeat (3) @(negedge clk);

        done = 1'b1;
        report();
    end

endmodule